// File: doc/BRIEF.md
# Two-State Difference-Metric Add-Compare-Select Unit

This unit is the add-compare-select stage of a maximum-likelihood sequence detector for a two-state trellis whose ideal received levels are negative, zero and positive (a one-minus-delay channel). It does not keep the two path metrics. It keeps only their difference: the metric of state 0 minus the metric of state 1. The sample is shifted up and down by half the nominal signal level, and comparing the stored difference against these two shifted values is enough to choose both survivors. No multiply and no squaring is needed. The squared-sample term is common to every branch, so it drops out. After scaling, the branch costs become the sample plus the half level and the negated sample plus the half level.

On every clock where the valid strobe is high, the unit takes one signed sample and the current half-level constant. It moves the difference register to the upper threshold, moves it to the lower threshold, or leaves it where it is. One cycle later it presents the matching two-bit survivor decision to a path memory. The half level is an input, so the detector can follow a gain setting without a change to the design.

Top module: `dmetric_acs`

## Requirements
- R1: While `rst_n` is low, and until the first sample after reset, `diff_o` is 0, `dec_vld_o` is 0 and `dec_o` is 2'b10.
- R2: A valid sample with the stored difference strictly above `smp_i + half_i` loads `smp_i + half_i` into the difference. The decision is 2'b11: both states survive from state 1.
- R3: A valid sample with the stored difference strictly below `smp_i - half_i` loads `smp_i - half_i` into the difference. The decision is 2'b00: both states survive from state 0.
- R4: A valid sample with the stored difference between `smp_i - half_i` and `smp_i + half_i`, both ends included, leaves the difference unchanged. The decision is 2'b10: each state survives from itself. Bit 1 of a decision is the predecessor of state 1 and bit 0 is the predecessor of state 0. The comparator combination "above the upper threshold and below the lower one" is treated the same way.
- R5: A cycle with `smp_vld_i` low leaves `diff_o` and `dec_o` unchanged and drives `dec_vld_o` low in the next cycle, whatever `smp_i` and `half_i` carry.
- R6: The new difference and decision appear on the clock edge that samples the strobe. `dec_vld_o` is high in exactly the cycle after each strobe. Strobes in back-to-back cycles each update the difference.
- R7: The thresholds are formed one bit wider than the sample, so samples and half levels at full scale compare correctly and never wrap.
- R8: The difference always stays within the signed range of the sample width.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the unit |
| smp_vld_i | input | 1 | Sample strobe |
| smp_i | input | SMP_W | Signed two's-complement equalized sample |
| half_i | input | SMP_W-1 | Unsigned half of the nominal signal level |
| diff_o | output | SMP_W+1 | Signed metric difference, state 0 minus state 1 |
| dec_vld_o | output | 1 | Decision valid, one cycle after a strobe |
| dec_o | output | 2 | Survivor decision: bit 1 is the predecessor of state 1, bit 0 is the predecessor of state 0 |

## Verification
The sweep is run at a five-bit sample width. Each stored difference in the reachable range is first loaded by a sample with a zero half level. Every sample value and every half level is then applied to it, so the bench sees the three update regions and the exact tie points where the difference equals a threshold. Those tie points are what separate strict from inclusive comparisons. The full-scale corners, such as a positive maximum sample with a maximum half level, show whether the thresholds are formed wide enough. An idle cycle with scrambled inputs follows every update, and it shows whether the strobe gates the registers.

// File: rtl/dm_pkg.sv
package dm_pkg;
  // bit 1: predecessor of state 1, bit 0: predecessor of state 0
  typedef enum logic [1:0] {
    DEC_ALL_S0 = 2'b00,
    DEC_OWN    = 2'b10,
    DEC_ALL_S1 = 2'b11
  } dec_e;
endpackage

// File: rtl/dm_rst_sync.sv
module dm_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/dm_thresh.sv
module dm_thresh #(
  parameter int SMP_W = 8,
  localparam int HALF_W = SMP_W - 1,
  localparam int DW = SMP_W + 1
) (
  input  logic signed [SMP_W-1:0]  smp,
  input  logic        [HALF_W-1:0] half,
  output logic signed [DW-1:0]     thr_hi,
  output logic signed [DW-1:0]     thr_lo
);
  logic signed [DW-1:0] smp_x;
  logic signed [DW-1:0] half_x;

  assign smp_x  = {smp[SMP_W-1], smp};
  assign half_x = {{(DW-HALF_W){1'b0}}, half};

  // one adder per threshold; g=0 forms the upper, g=1 the lower
  for (genvar g = 0; g < 2; g++) begin : g_thr
    if (g == 0) begin : g_hi
      assign thr_hi = smp_x + half_x;
    end else begin : g_lo
      assign thr_lo = smp_x - half_x;
    end
  end
endmodule

// File: rtl/dm_select.sv
module dm_select
  import dm_pkg::*;
#(
  parameter int DW = 9
) (
  input  logic signed [DW-1:0] diff_cur,
  input  logic signed [DW-1:0] thr_hi,
  input  logic signed [DW-1:0] thr_lo,
  output logic signed [DW-1:0] diff_new,
  output dec_e                 dec_new
);
  logic above;
  logic below;

  assign above = diff_cur > thr_hi;
  assign below = diff_cur < thr_lo;

  always_comb begin
    diff_new = diff_cur;
    dec_new  = DEC_OWN;
    unique case ({above, below})
      2'b10: begin
        diff_new = thr_hi;
        dec_new  = DEC_ALL_S1;
      end
      2'b01: begin
        diff_new = thr_lo;
        dec_new  = DEC_ALL_S0;
      end
      default: begin
        // inside the window, or the unreachable double hit: hold
        diff_new = diff_cur;
        dec_new  = DEC_OWN;
      end
    endcase
  end
endmodule

// File: rtl/dmetric_acs.sv
module dmetric_acs
  import dm_pkg::*;
#(
  parameter int SMP_W = 8,
  localparam int HALF_W = SMP_W - 1,
  localparam int DW = SMP_W + 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    smp_vld_i,
  input  logic signed [SMP_W-1:0] smp_i,
  input  logic [HALF_W-1:0]       half_i,
  output logic signed [DW-1:0]    diff_o,
  output logic                    dec_vld_o,
  output logic [1:0]              dec_o
);
  logic                 rst_sync_n;
  logic signed [DW-1:0] thr_hi, thr_lo;
  logic signed [DW-1:0] sel_diff;
  dec_e                 sel_dec;

  logic signed [DW-1:0] diff_q, diff_d;
  dec_e                 dec_q, dec_d;
  logic                 dvld_q, dvld_d;

  dm_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  dm_thresh #(.SMP_W(SMP_W)) u_thr (
    .smp    (smp_i),
    .half   (half_i),
    .thr_hi (thr_hi),
    .thr_lo (thr_lo)
  );

  dm_select #(.DW(DW)) u_sel (
    .diff_cur (diff_q),
    .thr_hi   (thr_hi),
    .thr_lo   (thr_lo),
    .diff_new (sel_diff),
    .dec_new  (sel_dec)
  );

  always_comb begin
    diff_d = diff_q;
    dec_d  = dec_q;
    dvld_d = smp_vld_i;
    if (smp_vld_i) begin
      diff_d = sel_diff;
      dec_d  = sel_dec;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      diff_q <= '0;
      dec_q  <= DEC_OWN;
      dvld_q <= 1'b0;
    end else begin
      diff_q <= diff_d;
      dec_q  <= dec_d;
      dvld_q <= dvld_d;
    end
  end

  assign diff_o    = diff_q;
  assign dec_o     = dec_q;
  assign dec_vld_o = dvld_q;
endmodule

// File: rtl/dmetric_acs_chk.sv
module dmetric_acs_chk #(
  parameter int SMP_W = 8,
  localparam int HALF_W = SMP_W - 1,
  localparam int DW = SMP_W + 1
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    rst_ok,
  input logic                    smp_vld_i,
  input logic signed [SMP_W-1:0] smp_i,
  input logic [HALF_W-1:0]       half_i,
  input logic signed [DW-1:0]    diff_o,
  input logic                    dec_vld_o,
  input logic [1:0]              dec_o
);
  int hi_v, lo_v, d_v;
  localparam int SMAX = (1 << (SMP_W-1)) - 1;
  localparam int SMIN = -(1 << (SMP_W-1));

  always_comb begin
    hi_v = int'(smp_i) + int'(half_i);
    lo_v = int'(smp_i) - int'(half_i);
    d_v  = int'(diff_o);
  end

  a_r1_reset_state: assert property (@(posedge clk)
    !rst_n |=> (diff_o == '0 && !dec_vld_o && dec_o == 2'b10));

  a_r2_above: assert property (@(posedge clk) disable iff (!rst_ok)
    (smp_vld_i && d_v > hi_v) |=> (d_v == $past(hi_v) && dec_o == 2'b11));

  a_r3_below: assert property (@(posedge clk) disable iff (!rst_ok)
    (smp_vld_i && d_v < lo_v) |=> (d_v == $past(lo_v) && dec_o == 2'b00));

  a_r4_keep: assert property (@(posedge clk) disable iff (!rst_ok)
    (smp_vld_i && d_v <= hi_v && d_v >= lo_v) |=> ($stable(diff_o) && dec_o == 2'b10));

  a_r5_idle: assert property (@(posedge clk) disable iff (!rst_ok)
    !smp_vld_i |=> ($stable(diff_o) && $stable(dec_o) && !dec_vld_o));

  a_r6_strobe: assert property (@(posedge clk) disable iff (!rst_ok)
    smp_vld_i |=> dec_vld_o);

  a_r8_bounded: assert property (@(posedge clk) disable iff (!rst_ok)
    (d_v <= SMAX && d_v >= SMIN));
endmodule

bind dmetric_acs dmetric_acs_chk #(.SMP_W(SMP_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .rst_ok    (rst_sync_n),
  .smp_vld_i (smp_vld_i),
  .smp_i     (smp_i),
  .half_i    (half_i),
  .diff_o    (diff_o),
  .dec_vld_o (dec_vld_o),
  .dec_o     (dec_o)
);

// File: tb/tb_dmetric_acs.sv
module tb_dmetric_acs;
  localparam int CLK_PERIOD = 10;
  localparam int SW = 5;
  localparam int HW = SW - 1;
  localparam int DW = SW + 1;
  localparam int SMAX = (1 << (SW-1)) - 1;
  localparam int SMIN = -(1 << (SW-1));
  localparam int HMAX = (1 << HW) - 1;

  logic                 clk;
  logic                 rst_n;
  logic                 vld;
  logic signed [SW-1:0] smp;
  logic [HW-1:0]        half;
  logic signed [DW-1:0] diff;
  logic                 dvld;
  logic [1:0]           dec;

  int checks;
  int errors;
  bit done;

  dmetric_acs #(.SMP_W(SW)) dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .smp_vld_i (vld),
    .smp_i     (smp),
    .half_i    (half),
    .diff_o    (diff),
    .dec_vld_o (dvld),
    .dec_o     (dec)
  );

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD/2) clk = ~clk;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // inputs applied at a falling edge, results read at the next falling edge
  task automatic step(input bit v, input int y, input int h);
    vld  = v;
    smp  = SW'(y);
    half = HW'(h);
    @(negedge clk);
  endtask

  initial begin
    int cyc;
    cyc = 0;
    while (!done && cyc < 200000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      check(1'b0, "watchdog", cyc, 200000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    checks = 0;
    errors = 0;
    done   = 1'b0;
    rst_n  = 1'b0;
    vld    = 1'b0;
    smp    = '0;
    half   = '0;
    repeat (3) @(negedge clk);
    // R1: reset state while held in reset
    check(diff == 0, "R1 diff", int'(diff), 0);
    check(dvld == 1'b0, "R1 dec_vld", int'(dvld), 0);
    check(dec == 2'b10, "R1 dec", int'(dec), 2);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(diff == 0 && dvld == 1'b0, "R1 after release", int'(diff), 0);

    for (int d = SMIN; d <= SMAX; d++) begin
      for (int y = SMIN; y <= SMAX; y++) begin
        for (int h = 0; h <= HMAX; h++) begin
          int hi, lo, ed, edec;
          string tag;
          // load the stored difference: zero half level sets it to the sample
          step(1'b1, d, 0);
          check(diff == DW'(d) && dvld, "R6 load", int'(diff), d);
          hi = y + h;
          lo = y - h;
          if (d > hi) begin
            ed = hi; edec = 3; tag = "R2";
          end else if (d < lo) begin
            ed = lo; edec = 0; tag = "R3";
          end else begin
            ed = d; edec = 2; tag = "R4";
          end
          if (hi > SMAX || lo < SMIN) tag = {tag, " R7"};
          step(1'b1, y, h);
          check(int'(diff) == ed, {tag, " diff"}, int'(diff), ed);
          check(int'(dec) == edec && dvld, {tag, " dec"}, int'(dec), edec);
          check(int'(diff) <= SMAX && int'(diff) >= SMIN, "R8 range", int'(diff), ed);
          // R5: idle cycle with scrambled inputs has no effect
          step(1'b0, SMIN - y - 1, HMAX - h);
          check(int'(diff) == ed && int'(dec) == edec && !dvld, "R5 idle",
                int'(diff), ed);
        end
      end
    end
    vld = 1'b0;
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule